// File: doc/BRIEF.md
# DRAM Page-Hit Request Address Generator

This block produces a stream of memory request addresses, each with a read/write flag, for loading a DRAM controller with traffic whose page-hit length is controlled. Requests come in series. Every request in one series targets the same row, bank and rank, on successive columns of one page. The series length is programmable, from one burst up to a whole page.

At the start of each series the block draws several values from an internal 32-bit LFSR. It draws a base address inside the configured window, a starting column that leaves room for the whole series in the page, a bank from the banks in use, a rank, and the read/write decision. It then places the column, bank and rank fields into the base under one of two address layouts. Requests leave through a valid/ready interface, and the first request of each series carries a marker.

The configuration inputs must stay stable while the block runs. To change the configuration, apply reset.

Top module: `dram_hit_addrgen`

## Requirements
- R1: While reqValid is high and reqReady is low, reqValid stays high and reqAddr, reqIsRead and reqFirst hold their values. The block moves to the next request only on a cycle with both valid and ready high.
- R2: Each series has exactly cfgSeriesLen requests. reqFirst is 1 on the first request of a series and 0 on the others.
- R3: The starting column plus cfgSeriesLen never exceeds the columns per page (PAGE_BYTES/BURST_BYTES, 16 by default). Row, bank and rank stay the same across a series, and the column rises by one per request.
- R4: Layout 1 places fields from bit 0 upward as block offset (log2 BURST_BYTES bits), column, bank, then rank. Within a series each request address is the previous one plus BURST_BYTES. Default positions are column [9:6], bank [12:10] and rank [13].
- R5: Layout 0 places fields from bit 0 upward as block offset, bank, rank, then column. Within a series the column field is incremented in place. Default positions are bank [8:6], rank [9] and column [13:10].
- R6: cfgMapSel equal to 0 selects layout 0. Values 1, 2 and 3 all select layout 1.
- R7: The bank field is below cfgBanksUsed and the rank field is below RANKS. With RANKS equal to 1 the address has no rank field.
- R8: The read/write flag is chosen once per series. cfgReadPct of 100 or more gives only reads, 0 gives only writes, and 50 gives series of both kinds.
- R9: The block offset bits of every address are zero. The address bits above all fields equal those of a value in [cfgStartAddr, cfgEndAddr).
- R10: reqValid is low while reset is held. The same SEED and the same ready pattern after reset reproduce the same request sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStartAddr | input | ADDR_W | Lowest base address of the window |
| cfgEndAddr | input | ADDR_W | One past the highest base address (must exceed start) |
| cfgSeriesLen | input | log2(cols)+1 | Requests per series, 1 to columns per page |
| cfgBanksUsed | input | log2(BANKS)+1 | Number of banks drawn from, 1 to BANKS |
| cfgReadPct | input | 7 | Read percentage |
| cfgMapSel | input | 2 | Address layout select |
| reqValid | output | 1 | Request valid |
| reqReady | input | 1 | Request accepted when high with valid |
| reqAddr | output | ADDR_W | Request byte address |
| reqIsRead | output | 1 | 1 for read, 0 for write |
| reqFirst | output | 1 | Marks the first request of a series |

## Verification
The bench targets the following corner cases:
- **Full-page series.** A series as long as a whole page forces the start column to 0. A wrong column bound would let the series overflow into the bank field.
- **Layout mix-ups.** If layout 0 advanced by adding a burst, or if a select value of 2 fell into layout 0, the column would spill into the bank field, or the bank would be found at the wrong bits. The bench catches both by decoding bank and column at the positions of the expected layout.
- **Narrow window and single bank.** A narrow address window and a single bank in use show range reduction that escapes its bound.
- **Back-pressure.** Random ready stalls catch a request that changes while it waits.
- **Reproducibility.** Two identical runs after reset must match, which catches an LFSR that does not restart from its seed.

// File: rtl/dram_hit_pkg.sv
package dram_hit_pkg;

  // strobes from the control sequencer to the datapath
  typedef struct packed {
    logic capBase;
    logic capCol;
    logic capBank;
    logic capRank;
    logic capRw;
    logic build;
    logic advance;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_BASE,
    ST_COL,
    ST_BANK,
    ST_RANK,
    ST_RW,
    ST_BUILD,
    ST_ISSUE
  } genState_t;

endpackage

// File: rtl/dram_hit_dp.sv
module dram_hit_dp
  import dram_hit_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          BLK_W  = 6,
  parameter int          COL_W  = 4,
  parameter int          BANK_W = 3,
  parameter int          RANK_W = 1,
  parameter logic [31:0] SEED   = 32'h1ACE_B00C
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [ADDR_W-1:0] cfgEndAddr,
  input  logic [COL_W:0]    cfgSeriesLen,
  input  logic [BANK_W:0]   cfgBanksUsed,
  input  logic [6:0]        cfgReadPct,
  input  logic              mapOne,
  output logic              fitBase,
  output logic              fitCol,
  output logic              fitBank,
  output logic              fitRw,
  output logic [ADDR_W-1:0] addrOut,
  output logic              isReadOut
);
  localparam int COLS     = 1 << COL_W;
  localparam int FIELD_W  = COL_W + BANK_W + RANK_W;
  localparam int COL0_POS = BLK_W + BANK_W + RANK_W;
  localparam logic [ADDR_W-1:0] BURST      = ADDR_W'(1) << BLK_W;
  localparam logic [ADDR_W-1:0] BLK_MASK   = BURST - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FIELD_MASK = ((ADDR_W'(1) << FIELD_W) - ADDR_W'(1)) << BLK_W;
  localparam logic [ADDR_W-1:0] COL0_MASK  = ((ADDR_W'(1) << COL_W) - ADDR_W'(1)) << COL0_POS;
  localparam logic [31:0] SEED_NZ = (SEED == 32'd0) ? 32'd1 : SEED;

  logic [31:0]       lfsr;
  logic [ADDR_W-1:0] rnd, span, spanMask, drawOff;
  logic [COL_W:0]    colLimit, colMask, drawCol;
  logic [BANK_W:0]   bankMask, drawBank;
  logic [6:0]        drawPct;
  logic [ADDR_W-1:0] baseReg, addrReg, built, colTerm, bankTerm, rankTerm, stepped;
  logic [COL_W-1:0]  colReg, colNow;
  logic [BANK_W-1:0] bankReg;
  logic              readReg;

  // random source, one step per clock
  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= SEED_NZ;
    else       lfsr <= lfsr[0] ? ((lfsr >> 1) ^ 32'h8000_0057) : (lfsr >> 1);
  end

  // range reduction by masking to the next power of two and retrying
  always_comb begin
    rnd      = ADDR_W'({lfsr, lfsr});
    span     = cfgEndAddr - cfgStartAddr;
    spanMask = span - ADDR_W'(1);
    for (int s = 0; s < ADDR_W; s++) spanMask = spanMask | (spanMask >> 1);
    drawOff  = rnd & spanMask;
    fitBase  = drawOff < span;

    colLimit = (COL_W+1)'(COLS) - cfgSeriesLen;
    colMask  = colLimit;
    for (int s = 0; s <= COL_W; s++) colMask = colMask | (colMask >> 1);
    drawCol  = rnd[COL_W:0] & colMask;
    fitCol   = drawCol <= colLimit;

    bankMask = cfgBanksUsed - (BANK_W+1)'(1);
    for (int s = 0; s <= BANK_W; s++) bankMask = bankMask | (bankMask >> 1);
    drawBank = rnd[BANK_W:0] & bankMask;
    fitBank  = drawBank < cfgBanksUsed;

    drawPct  = rnd[6:0];
    fitRw    = drawPct < 7'd100;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      colReg  <= '0;
      bankReg <= '0;
      readReg <= 1'b0;
    end else begin
      if (stb.capBase) baseReg <= (cfgStartAddr + drawOff) & ~BLK_MASK;
      if (stb.capCol)  colReg  <= drawCol[COL_W-1:0];
      if (stb.capBank) bankReg <= drawBank[BANK_W-1:0];
      if (stb.capRw)   readReg <= drawPct < cfgReadPct;
    end
  end

  generate
    if (RANK_W > 0) begin : g_rank
      logic [RANK_W-1:0] rankReg;
      always_ff @(posedge clk) begin
        if (!rstN)            rankReg <= '0;
        else if (stb.capRank) rankReg <= rnd[RANK_W-1:0];
      end
      assign rankTerm = ADDR_W'(rankReg) << (mapOne ? (BLK_W + COL_W + BANK_W) : (BLK_W + BANK_W));
    end else begin : g_norank
      assign rankTerm = '0;
    end
  endgenerate

  // field placement and in-series stepping
  always_comb begin
    colTerm  = ADDR_W'(colReg)  << (mapOne ? BLK_W : COL0_POS);
    bankTerm = ADDR_W'(bankReg) << (mapOne ? (BLK_W + COL_W) : BLK_W);
    built    = (baseReg & ~FIELD_MASK) | colTerm | bankTerm | rankTerm;
    colNow   = addrReg[COL0_POS +: COL_W];
    stepped  = mapOne ? (addrReg + BURST)
                      : ((addrReg & ~COL0_MASK) | (ADDR_W'(colNow + COL_W'(1)) << COL0_POS));
  end

  always_ff @(posedge clk) begin
    if (!rstN)            addrReg <= '0;
    else if (stb.build)   addrReg <= built;
    else if (stb.advance) addrReg <= stepped;
  end

  assign addrOut   = addrReg;
  assign isReadOut = readReg;
endmodule

// File: rtl/dram_hit_ctl.sv
module dram_hit_ctl
  import dram_hit_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fitBase,
  input  logic             fitCol,
  input  logic             fitBank,
  input  logic             fitRw,
  input  logic [LEN_W-1:0] cfgSeriesLen,
  input  logic             reqReady,
  output dpStrobe_t        stb,
  output logic             reqValid,
  output logic             reqFirst
);
  genState_t        state, nextState;
  logic [LEN_W-1:0] remaining;
  logic             firstReg;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_BASE:  if (fitBase) begin stb.capBase = 1'b1; nextState = ST_COL;  end
      ST_COL:   if (fitCol)  begin stb.capCol  = 1'b1; nextState = ST_BANK; end
      ST_BANK:  if (fitBank) begin stb.capBank = 1'b1; nextState = ST_RANK; end
      ST_RANK:  begin stb.capRank = 1'b1; nextState = ST_RW; end
      ST_RW:    if (fitRw)   begin stb.capRw   = 1'b1; nextState = ST_BUILD; end
      ST_BUILD: begin stb.build = 1'b1; nextState = ST_ISSUE; end
      ST_ISSUE: if (reqReady) begin
                  if (remaining == LEN_W'(1)) nextState = ST_BASE;
                  else                        stb.advance = 1'b1;
                end
      default:  nextState = ST_BASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_BASE;
      remaining <= '0;
      firstReg  <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.build) begin
        remaining <= cfgSeriesLen;
        firstReg  <= 1'b1;
      end else if (stb.advance) begin
        remaining <= remaining - LEN_W'(1);
        firstReg  <= 1'b0;
      end
    end
  end

  assign reqValid = (state == ST_ISSUE);
  assign reqFirst = firstReg;
endmodule

// File: rtl/dram_hit_addrgen.sv
module dram_hit_addrgen
  import dram_hit_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          BURST_BYTES = 64,
  parameter int          PAGE_BYTES  = 1024,
  parameter int          BANKS       = 8,
  parameter int          RANKS       = 2,
  parameter logic [31:0] SEED        = 32'h1ACE_B00C,
  localparam int BLK_W  = $clog2(BURST_BYTES),
  localparam int COL_W  = $clog2(PAGE_BYTES / BURST_BYTES),
  localparam int BANK_W = $clog2(BANKS),
  localparam int RANK_W = $clog2(RANKS),
  localparam int LEN_W  = COL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [ADDR_W-1:0] cfgEndAddr,
  input  logic [LEN_W-1:0]  cfgSeriesLen,
  input  logic [BANK_W:0]   cfgBanksUsed,
  input  logic [6:0]        cfgReadPct,
  input  logic [1:0]        cfgMapSel,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqIsRead,
  output logic              reqFirst
);
  dpStrobe_t stb;
  logic fitBase, fitCol, fitBank, fitRw;
  logic mapOne;

  assign mapOne = (cfgMapSel != 2'd0);

  dram_hit_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .fitBase(fitBase), .fitCol(fitCol), .fitBank(fitBank), .fitRw(fitRw),
    .cfgSeriesLen(cfgSeriesLen), .reqReady(reqReady),
    .stb(stb), .reqValid(reqValid), .reqFirst(reqFirst)
  );

  dram_hit_dp #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .COL_W(COL_W),
    .BANK_W(BANK_W), .RANK_W(RANK_W), .SEED(SEED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgStartAddr(cfgStartAddr), .cfgEndAddr(cfgEndAddr),
    .cfgSeriesLen(cfgSeriesLen), .cfgBanksUsed(cfgBanksUsed),
    .cfgReadPct(cfgReadPct), .mapOne(mapOne),
    .fitBase(fitBase), .fitCol(fitCol), .fitBank(fitBank), .fitRw(fitRw),
    .addrOut(reqAddr), .isReadOut(reqIsRead)
  );
endmodule

// File: rtl/dram_hit_addrgen_chk.sv
module dram_hit_addrgen_chk #(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 6,
  parameter int COL_W  = 4,
  parameter int BANK_W = 3,
  parameter int RANK_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [COL_W:0]    cfgSeriesLen,
  input logic [BANK_W:0]   cfgBanksUsed,
  input logic [6:0]        cfgReadPct,
  input logic [1:0]        cfgMapSel,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqIsRead,
  input logic              reqFirst
);
  localparam int COLS = 1 << COL_W;
  logic [COL_W-1:0]  colAt;
  logic [BANK_W-1:0] bankAt;

  always_comb begin
    if (cfgMapSel != 2'd0) begin
      colAt  = reqAddr[BLK_W +: COL_W];
      bankAt = reqAddr[BLK_W + COL_W +: BANK_W];
    end else begin
      colAt  = reqAddr[BLK_W + BANK_W + RANK_W +: COL_W];
      bankAt = reqAddr[BLK_W +: BANK_W];
    end
  end

  // R1
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqIsRead) && $stable(reqFirst));

  // R9
  block_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqAddr[BLK_W-1:0] == '0);

  // R3
  col_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqFirst |-> ({1'b0, colAt} + cfgSeriesLen) <= (COL_W+1)'(COLS));

  // R7
  bank_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> {1'b0, bankAt} < cfgBanksUsed);

  // R8
  all_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && cfgReadPct >= 7'd100 |-> reqIsRead);

  // R8
  all_writes_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && cfgReadPct == 7'd0 |-> !reqIsRead);

  // R8
  rw_per_series_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqFirst && $past(reqValid && reqReady) |-> reqIsRead == $past(reqIsRead));
endmodule

bind dram_hit_addrgen dram_hit_addrgen_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .COL_W(COL_W), .BANK_W(BANK_W), .RANK_W(RANK_W)
) u_chk (.*);

// File: tb/dram_hit_addrgen_bench.sv
`timescale 1ns/1ps
module dram_hit_addrgen_bench;
  localparam int ADDR_W = 32;
  localparam int BLK_W  = 6;
  localparam int COL_W  = 4;
  localparam int BANK_W = 3;
  localparam int RANK_W = 1;
  localparam int COLS   = 16;
  localparam int ROW_SH = BLK_W + COL_W + BANK_W + RANK_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] cfgStartAddr = '0, cfgEndAddr = 32'h1000;
  logic [COL_W:0] cfgSeriesLen = 5'd1;
  logic [BANK_W:0] cfgBanksUsed = 4'd1;
  logic [6:0] cfgReadPct = '0;
  logic [1:0] cfgMapSel = '0;
  logic reqValid, reqReady = 1'b0, reqIsRead, reqFirst;
  logic [ADDR_W-1:0] reqAddr;

  always #2 clk = ~clk;

  dram_hit_addrgen u_dram_hit_addrgen (
    .clk(clk), .rstN(rstN), .cfgStartAddr(cfgStartAddr), .cfgEndAddr(cfgEndAddr),
    .cfgSeriesLen(cfgSeriesLen), .cfgBanksUsed(cfgBanksUsed), .cfgReadPct(cfgReadPct),
    .cfgMapSel(cfgMapSel), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqIsRead(reqIsRead), .reqFirst(reqFirst)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [ADDR_W-1:0] capA [12];
  logic [ADDR_W-1:0] capB [12];
  int capN;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int colOf(input logic [ADDR_W-1:0] a, input logic [1:0] m);
    return (m != 0) ? int'(a[BLK_W +: COL_W]) : int'(a[BLK_W+BANK_W+RANK_W +: COL_W]);
  endfunction
  function automatic int bankOf(input logic [ADDR_W-1:0] a, input logic [1:0] m);
    return (m != 0) ? int'(a[BLK_W+COL_W +: BANK_W]) : int'(a[BLK_W +: BANK_W]);
  endfunction
  function automatic int rankOf(input logic [ADDR_W-1:0] a, input logic [1:0] m);
    return (m != 0) ? int'(a[BLK_W+COL_W+BANK_W]) : int'(a[BLK_W+BANK_W]);
  endfunction
  function automatic logic [ADDR_W-1:0] nextExp(input logic [ADDR_W-1:0] a0, input int k,
                                                input logic [1:0] m);
    logic [ADDR_W-1:0] e;
    if (m != 0) e = a0 + ADDR_W'(k * 64);
    else begin
      e = a0;
      e[BLK_W+BANK_W+RANK_W +: COL_W] = COL_W'(colOf(a0, m) + k);
    end
    return e;
  endfunction

  task automatic runCfg(input logic [ADDR_W-1:0] st, input logic [ADDR_W-1:0] en,
                        input int len, input int banks, input int pct, input int m,
                        input int cycles, input bit alwaysReady, input bit capture);
    string mapTag;
    logic [ADDR_W-1:0] a0, heldAddr;
    bit rw0, haveSeries, holdPending, heldFirst, heldRw, r;
    int cnt, rdSeries, wrSeries;
    mapTag = (m == 0) ? "R5" : ((m == 1) ? "R4" : "R6");
    haveSeries = 0; holdPending = 0; cnt = 0; rdSeries = 0; wrSeries = 0;
    heldAddr = '0; heldFirst = 0; heldRw = 0; a0 = '0; rw0 = 0; capN = 0;
    @(negedge clk);
    rstN = 1'b0; reqReady = 1'b0;
    cfgStartAddr = st; cfgEndAddr = en; cfgSeriesLen = 5'(len);
    cfgBanksUsed = 4'(banks); cfgReadPct = 7'(pct); cfgMapSel = 2'(m);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(reqValid == 1'b0, "R10", "valid during reset", reqValid, 0);
    end
    rstN = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (holdPending) begin
        chk(reqValid, "R1", "valid dropped while stalled", reqValid, 1);
        chk(reqAddr == heldAddr && reqFirst == heldFirst && reqIsRead == heldRw,
            "R1", "request changed while stalled", reqAddr, heldAddr);
      end
      r = alwaysReady ? 1'b1 : ($urandom % 3 != 0);
      if (reqValid && r) begin
        if (capture && capN < 12) begin capA[capN] = reqAddr; capN++; end
        if (reqFirst) begin
          if (haveSeries) chk(cnt == len, "R2", "series length", cnt, len);
          chk(reqAddr[BLK_W-1:0] == 0, "R9", "block offset", reqAddr[BLK_W-1:0], 0);
          chk((reqAddr >> ROW_SH) >= (st >> ROW_SH) && (reqAddr >> ROW_SH) <= ((en - 1) >> ROW_SH),
              "R9", "row bits outside window", reqAddr >> ROW_SH, st >> ROW_SH);
          chk(colOf(reqAddr, 2'(m)) + len <= COLS, "R3", "start column room",
              colOf(reqAddr, 2'(m)), COLS - len);
          chk(bankOf(reqAddr, 2'(m)) < banks, (m >= 2) ? "R6" : "R7", "bank bound",
              bankOf(reqAddr, 2'(m)), banks - 1);
          chk(rankOf(reqAddr, 2'(m)) < 2, "R7", "rank bound", rankOf(reqAddr, 2'(m)), 1);
          if (pct >= 100) chk(reqIsRead, "R8", "pct 100 gave write", reqIsRead, 1);
          if (pct == 0) chk(!reqIsRead, "R8", "pct 0 gave read", reqIsRead, 0);
          if (reqIsRead) rdSeries++; else wrSeries++;
          a0 = reqAddr; rw0 = reqIsRead; cnt = 1; haveSeries = 1;
        end else begin
          chk(haveSeries && cnt < len, "R2", "unmarked extra request", cnt, len);
          chk(reqAddr == nextExp(a0, cnt, 2'(m)), mapTag, "in-series address",
              reqAddr, nextExp(a0, cnt, 2'(m)));
          chk(reqIsRead == rw0, "R8", "rw changed inside series", reqIsRead, rw0);
          cnt++;
        end
      end
      holdPending = reqValid && !r;
      heldAddr = reqAddr; heldFirst = reqFirst; heldRw = reqIsRead;
      reqReady = r;
    end
    if (pct == 50)
      chk(rdSeries > 0 && wrSeries > 0, "R8", "pct 50 lacks a kind", rdSeries, wrSeries);
  endtask

  initial begin
    void'($urandom(1234));
    // layout 1, reads only, random stalls
    runCfg(32'h0001_0000, 32'h0009_0000, 4, 8, 100, 1, 2500, 0, 0);
    // layout 0, full-page series, writes only
    runCfg(32'h0040_0000, 32'h0080_0000, 16, 3, 0, 0, 2500, 0, 0);
    // select 2 falls back to layout 1, single bank, one-burst series
    runCfg(32'h0000_0000, 32'h0100_0000, 1, 1, 50, 2, 2500, 0, 0);
    // layout 0, narrow window, mixed
    runCfg(32'h0000_1234, 32'h0000_1300, 5, 5, 50, 0, 3000, 0, 0);
    // select 3, layout 1, long series
    runCfg(32'h1000_0000, 32'h2000_0000, 12, 8, 50, 3, 2500, 0, 0);
    // reproducibility after reset
    runCfg(32'h0002_0000, 32'h0006_0000, 3, 6, 50, 1, 400, 1, 1);
    for (int i = 0; i < 12; i++) capB[i] = capA[i];
    runCfg(32'h0002_0000, 32'h0006_0000, 3, 6, 50, 1, 400, 1, 1);
    chk(capN == 12, "R10", "captured count", capN, 12);
    for (int i = 0; i < 12; i++)
      chk(capA[i] == capB[i], "R10", "sequence repeat", capA[i], capB[i]);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule